// File: doc/BRIEF.md
# Masked Interrupt Vector Controller

The block collects interrupt requests for a processor core. Thirty level-sensitive request lines pass through a software-written enable mask. When any enabled line is active the block raises a request wire toward the core and puts an 8-bit code on a vector bus. A single active line gets its own code, 0x31 plus its bit position. Two or more active lines share the code 0x30, and the handler reads the pending registers to decide which one to serve first.

Two further lines are non-maskable. Each is reflected in a status register and, together, they drive a separate request output that the mask never touches.

A 32-bit register bus lets software read the mask, the raw line levels, the enabled-and-active lines and the non-maskable status. Only the mask can be written. An offset outside the decoded window, or a misaligned one, answers with zero and pulses an error flag.

Top module: `mivc_top`

## Requirements
- R1: The enable mask resets to 0. A write at offset 0x00 loads it, keeping only bits 29..0. A read at 0x00 returns it zero-extended to 32 bits.
- R2: A read at 0x04 returns the present input levels, with line n (numbered from 1) in bit n-1. A read at 0x08 returns those levels ANDed with the mask.
- R3: When exactly one enabled line, at bit i, is active, irq_vec is 0x31+i and irq_req is 1.
- R4: When two or more enabled lines are active, irq_vec is 0x30 and irq_req is 1.
- R5: When no enabled line is active, irq_vec is 0 and irq_req is 0, whatever the disabled lines do.
- R6: A read at 0x0C returns the levels of the two non-maskable lines in bits 1..0. nmi_req is 1 whenever either line is high, whatever the mask holds.
- R7: A read at 0x10 returns 0. A write to 0x04, 0x08, 0x0C or 0x10 leaves the mask unchanged and raises no error.
- R8: A read of an offset at or above 0x14, or of an offset whose low two bits are not zero, returns 0. A write to such an offset changes nothing. Either kind of access sets bus_err for exactly the one cycle after the access.
- R9: irq_vec, irq_req and nmi_req are registered. They reflect an input change on the clock edge after it. After a mask write they reflect the new mask one edge after the edge that loaded it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_in | input | 30 | Level-sensitive maskable request lines, line n on bit n-1 |
| nmi_in | input | 2 | Level-sensitive non-maskable request lines |
| bus_sel | input | 1 | Register access strobe, one access per cycle it is high |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 8 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after the access and held until the next |
| bus_err | output | 1 | One-cycle flag for an access to an unmapped offset |
| irq_req | output | 1 | Maskable interrupt request to the core |
| irq_vec | output | 8 | Vector code to the core |
| nmi_req | output | 1 | Non-maskable interrupt request to the core |

## Verification
Read data and the error flag are due one edge after the cycle in which bus_sel is high. The bench drives the access on a falling edge and samples on the next falling edge. The core-side outputs are due one edge after an input change, so every table row first sets lines and mask and then waits one full cycle before sampling. Directed cases also sample in the half cycle before that edge, to show the old value still holds. After a mask write they check that the output has not yet moved one edge after the write and has moved one edge later.

// File: rtl/mivc_pkg.sv
// Package: shared constants and decode helper for the masked interrupt
// vector controller. Assumes byte offsets on a 32-bit register bus.
package mivc_pkg;

    localparam int REG_DATA_W = 32;

    // Register byte offsets; decode depends on these values.
    localparam int OFF_MASK   = 'h00;
    localparam int OFF_RAW    = 'h04;
    localparam int OFF_EN     = 'h08;
    localparam int OFF_NMI    = 'h0C;
    localparam int OFF_FAULT  = 'h10;
    localparam int WINDOW_END = 'h14;

    typedef enum logic [2:0] {
        SEL_MASK  = 3'd0,
        SEL_RAW   = 3'd1,
        SEL_EN    = 3'd2,
        SEL_NMI   = 3'd3,
        SEL_FAULT = 3'd4,
        SEL_NONE  = 3'd7
    } reg_sel_e;

    // Map a byte offset to a register selector; unaligned or out of window
    // offsets give SEL_NONE.
    function automatic reg_sel_e decode_offset(input int unsigned off);
        if (off[1:0] != 2'b00 || off >= WINDOW_END) return SEL_NONE;
        case (off)
            OFF_MASK:  return SEL_MASK;
            OFF_RAW:   return SEL_RAW;
            OFF_EN:    return SEL_EN;
            OFF_NMI:   return SEL_NMI;
            default:   return SEL_FAULT;
        endcase
    endfunction

endpackage

// File: rtl/mivc_encoder.sv
// Module: mivc_encoder
// Purpose: purely combinational vector coder. Finds the lowest set bit of
// the enabled pending vector and flags whether more than one bit is set.
// Assumes NUM_IRQ + VEC_BASE fits in VEC_W bits.
module mivc_encoder #(
    parameter int NUM_IRQ   = 30,
    parameter int VEC_W     = 8,
    parameter int VEC_MULTI = 'h30,
    parameter int VEC_BASE  = 'h31
) (
    input  logic [NUM_IRQ-1:0] en_pend,
    output logic               any_act,
    output logic [VEC_W-1:0]   vec_code
);
    localparam int IDX_W = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1;

    logic [NUM_IRQ-1:0] lower_seen;
    logic [IDX_W-1:0]   low_idx_part [NUM_IRQ];
    logic [IDX_W-1:0]   low_idx;
    logic               multi;

    // Prefix chain: bit k is taken as lowest only if no lower bit is set.
    genvar k;
    generate
        for (k = 0; k < NUM_IRQ; k++) begin : g_scan
            if (k == 0) begin : g_first
                assign lower_seen[k]   = en_pend[k];
                assign low_idx_part[k] = '0;
            end else begin : g_rest
                assign lower_seen[k]   = lower_seen[k-1] | en_pend[k];
                assign low_idx_part[k] = lower_seen[k-1] ? low_idx_part[k-1]
                                       : (en_pend[k] ? IDX_W'(k) : low_idx_part[k-1]);
            end
        end
    endgenerate

    assign low_idx = low_idx_part[NUM_IRQ-1];
    assign any_act = lower_seen[NUM_IRQ-1];
    // More than one set bit when clearing the lowest leaves something.
    assign multi   = |(en_pend & (en_pend - NUM_IRQ'(1)));

    // Select the code sent to the core.
    always_comb begin
        if (!any_act)   vec_code = '0;
        else if (multi) vec_code = VEC_W'(VEC_MULTI);
        else            vec_code = VEC_W'(VEC_BASE) + VEC_W'(low_idx);
    end

    // A single active line never produces the shared code (R3).
    always_comb begin
        if ($onehot(en_pend))
            assert_single_code_R3: assert (vec_code != VEC_W'(VEC_MULTI) && vec_code != '0);
    end

endmodule

// File: rtl/mivc_regfile.sv
// Module: mivc_regfile
// Purpose: holds the enable mask and serves register reads with one cycle
// of latency. Assumes one access per cycle while bus_sel is high; unmapped
// accesses read zero and pulse bus_err.
module mivc_regfile
    import mivc_pkg::*;
#(
    parameter int NUM_IRQ = 30,
    parameter int NUM_NMI = 2,
    parameter int ADDR_W  = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_sel,
    input  logic                  bus_wr,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [REG_DATA_W-1:0] bus_wdata,
    input  logic [NUM_IRQ-1:0]    raw_pend,
    input  logic [NUM_IRQ-1:0]    en_pend,
    input  logic [NUM_NMI-1:0]    nmi_lvl,
    output logic [NUM_IRQ-1:0]    mask_q,
    output logic [REG_DATA_W-1:0] bus_rdata,
    output logic                  bus_err
);
    reg_sel_e              sel;
    logic [REG_DATA_W-1:0] rd_mux;

    assign sel = decode_offset(int'(unsigned'(bus_addr)));

    // Read multiplexer over the decoded register.
    always_comb begin
        case (sel)
            SEL_MASK: rd_mux = REG_DATA_W'(mask_q);
            SEL_RAW:  rd_mux = REG_DATA_W'(raw_pend);
            SEL_EN:   rd_mux = REG_DATA_W'(en_pend);
            SEL_NMI:  rd_mux = REG_DATA_W'(nmi_lvl);
            default:  rd_mux = '0;
        endcase
    end

    // Mask register: only writable location.
    always_ff @(posedge clk) begin
        if (!rst_n)                                  mask_q <= '0;
        else if (bus_sel && bus_wr && sel == SEL_MASK) mask_q <= bus_wdata[NUM_IRQ-1:0];
    end

    // Read data capture and error pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata <= '0;
            bus_err   <= 1'b0;
        end else begin
            bus_err <= bus_sel && (sel == SEL_NONE);
            if (bus_sel) bus_rdata <= bus_wr ? '0 : rd_mux;
        end
    end

    assert_mask_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(bus_sel && bus_wr) && $past(bus_addr) == ADDR_W'(OFF_MASK))
        |-> mask_q == $past(bus_wdata[NUM_IRQ-1:0]));

    assert_mask_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !($past(bus_sel && bus_wr) && $past(bus_addr) == ADDR_W'(OFF_MASK)))
        |-> $stable(mask_q));

    assert_err_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> bus_rdata == '0);

endmodule

// File: rtl/mivc_out_stage.sv
// Module: mivc_out_stage
// Purpose: registers the request and vector outputs toward the core so
// they change only on a clock edge. Assumes inputs settle within a cycle.
module mivc_out_stage #(
    parameter int NUM_NMI   = 2,
    parameter int VEC_W     = 8,
    parameter int VEC_MULTI = 'h30
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               any_act,
    input  logic [VEC_W-1:0]   vec_code,
    input  logic [NUM_NMI-1:0] nmi_lvl,
    output logic               irq_req,
    output logic [VEC_W-1:0]   irq_vec,
    output logic               nmi_req
);
    // Output registers; NMI request is the OR of all NMI lines.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_req <= 1'b0;
            irq_vec <= '0;
            nmi_req <= 1'b0;
        end else begin
            irq_req <= any_act;
            irq_vec <= vec_code;
            nmi_req <= |nmi_lvl;
        end
    end

    assert_code_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> irq_vec >= VEC_W'(VEC_MULTI));

    assert_idle_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_req |-> irq_vec == '0);

endmodule

// File: rtl/mivc_top.sv
// Module: mivc_top
// Purpose: masked interrupt vector controller. Gates level-sensitive lines
// through a software mask, codes one vector for the core (a shared code
// when several lines are active) and aggregates non-maskable lines.
// Assumes inputs are already synchronous to clk.
module mivc_top
    import mivc_pkg::*;
#(
    parameter int NUM_IRQ   = 30,
    parameter int NUM_NMI   = 2,
    parameter int ADDR_W    = 8,
    parameter int VEC_W     = 8,
    parameter int VEC_MULTI = 'h30,
    parameter int VEC_BASE  = 'h31
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_IRQ-1:0]    irq_in,
    input  logic [NUM_NMI-1:0]    nmi_in,
    input  logic                  bus_sel,
    input  logic                  bus_wr,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [REG_DATA_W-1:0] bus_wdata,
    output logic [REG_DATA_W-1:0] bus_rdata,
    output logic                  bus_err,
    output logic                  irq_req,
    output logic [VEC_W-1:0]      irq_vec,
    output logic                  nmi_req
);
    logic [NUM_IRQ-1:0] mask_q;
    logic [NUM_IRQ-1:0] en_pend;
    logic               any_act;
    logic [VEC_W-1:0]   vec_code;

    // Gate the live line levels through the mask.
    assign en_pend = irq_in & mask_q;

    mivc_regfile #(
        .NUM_IRQ (NUM_IRQ),
        .NUM_NMI (NUM_NMI),
        .ADDR_W  (ADDR_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .raw_pend  (irq_in),
        .en_pend   (en_pend),
        .nmi_lvl   (nmi_in),
        .mask_q    (mask_q),
        .bus_rdata (bus_rdata),
        .bus_err   (bus_err)
    );

    mivc_encoder #(
        .NUM_IRQ   (NUM_IRQ),
        .VEC_W     (VEC_W),
        .VEC_MULTI (VEC_MULTI),
        .VEC_BASE  (VEC_BASE)
    ) u_enc (
        .en_pend  (en_pend),
        .any_act  (any_act),
        .vec_code (vec_code)
    );

    mivc_out_stage #(
        .NUM_NMI   (NUM_NMI),
        .VEC_W     (VEC_W),
        .VEC_MULTI (VEC_MULTI)
    ) u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .any_act  (any_act),
        .vec_code (vec_code),
        .nmi_lvl  (nmi_in),
        .irq_req  (irq_req),
        .irq_vec  (irq_vec),
        .nmi_req  (nmi_req)
    );

    assert_irq_follow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> irq_req == $past(|(irq_in & mask_q)));

    assert_nmi_follow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> nmi_req == $past(|nmi_in));

endmodule

// File: tb/mivc_top_test.sv
`timescale 1ns/1ps
module mivc_top_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [29:0] irq_in = '0;
    logic [1:0]  nmi_in = '0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_err;
    logic        irq_req;
    logic [7:0]  irq_vec;
    logic        nmi_req;

    int n_checks = 0;
    int n_fails  = 0;

    always #2 clk = ~clk;   // 250 MHz

    mivc_top uut (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .nmi_in(nmi_in),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_err(bus_err),
        .irq_req(irq_req), .irq_vec(irq_vec), .nmi_req(nmi_req)
    );

    localparam int NROW = 8;
    localparam logic [31:0] T_MASK [NROW] = '{32'h0, 32'hFFFF_FFFF, 32'hFFFF_FFFF,
        32'hFFFF_FFFF, 32'h80, 32'h08, 32'hFFFF_FFFF, 32'h8000};
    localparam logic [29:0] T_IRQ [NROW] = '{30'h1, 30'h1, 30'h2000_0000,
        30'h88, 30'h88, 30'h80, 30'h3FFF_FFFF, 30'h8000};
    localparam logic [1:0] T_NMI [NROW] = '{2'b10, 2'b00, 2'b00, 2'b01,
        2'b11, 2'b00, 2'b00, 2'b00};
    localparam logic [7:0] T_VEC [NROW] = '{8'h00, 8'h31, 8'h4E, 8'h30,
        8'h38, 8'h00, 8'h30, 8'h40};

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One bus access: driven on a falling edge, result sampled on the next.
    task automatic bus_xfer(input logic wr, input logic [7:0] addr, input logic [31:0] wd,
                            output logic [31:0] rd, output logic err);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = wr; bus_addr = addr; bus_wdata = wd;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
        rd = bus_rdata; err = bus_err;
    endtask

    initial begin
        #(200000 * 4);
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        logic        er;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // Reset state (R1, R5)
        check("R5 reset irq_req", {31'b0, irq_req}, 32'h0);
        check("R5 reset irq_vec", {24'b0, irq_vec}, 32'h0);
        check("R6 reset nmi_req", {31'b0, nmi_req}, 32'h0);
        bus_xfer(1'b0, 8'h00, 32'h0, rd, er);
        check("R1 mask after reset", rd, 32'h0);

        // Table walk (R2..R6)
        for (int i = 0; i < NROW; i++) begin
            bus_xfer(1'b1, 8'h00, T_MASK[i], rd, er);
            @(negedge clk);
            irq_in = T_IRQ[i]; nmi_in = T_NMI[i];
            @(negedge clk);
            check($sformatf("R3/R4/R5 row %0d irq_vec", i), {24'b0, irq_vec}, {24'b0, T_VEC[i]});
            check($sformatf("R3/R4/R5 row %0d irq_req", i), {31'b0, irq_req},
                  {31'b0, (T_IRQ[i] & T_MASK[i][29:0]) != 0});
            check($sformatf("R6 row %0d nmi_req", i), {31'b0, nmi_req}, {31'b0, T_NMI[i] != 0});
            bus_xfer(1'b0, 8'h00, 32'h0, rd, er);
            check($sformatf("R1 row %0d mask readback", i), rd, {2'b0, T_MASK[i][29:0]});
            bus_xfer(1'b0, 8'h04, 32'h0, rd, er);
            check($sformatf("R2 row %0d raw", i), rd, {2'b0, T_IRQ[i]});
            bus_xfer(1'b0, 8'h08, 32'h0, rd, er);
            check($sformatf("R2 row %0d masked", i), rd, {2'b0, T_IRQ[i] & T_MASK[i][29:0]});
            bus_xfer(1'b0, 8'h0C, 32'h0, rd, er);
            check($sformatf("R6 row %0d nmi status", i), rd, {30'b0, T_NMI[i]});
        end

        // R7: fault register reads zero; writes to read-only offsets ignored
        bus_xfer(1'b1, 8'h00, 32'h0000_0010, rd, er);
        bus_xfer(1'b0, 8'h10, 32'h0, rd, er);
        check("R7 fault reg", rd, 32'h0);
        check("R7 fault reg no err", {31'b0, er}, 32'h0);
        bus_xfer(1'b1, 8'h04, 32'hFFFF_FFFF, rd, er);
        check("R7 ro write no err", {31'b0, er}, 32'h0);
        bus_xfer(1'b1, 8'h10, 32'hFFFF_FFFF, rd, er);
        bus_xfer(1'b0, 8'h00, 32'h0, rd, er);
        check("R7 mask kept", rd, 32'h0000_0010);

        // R8: unmapped and unaligned accesses
        bus_xfer(1'b0, 8'h14, 32'h0, rd, er);
        check("R8 unmapped read data", rd, 32'h0);
        check("R8 unmapped read err", {31'b0, er}, 32'h1);
        @(negedge clk);
        check("R8 err one cycle", {31'b0, bus_err}, 32'h0);
        bus_xfer(1'b1, 8'h18, 32'hFFFF_FFFF, rd, er);
        check("R8 unmapped write err", {31'b0, er}, 32'h1);
        bus_xfer(1'b0, 8'h02, 32'h0, rd, er);
        check("R8 unaligned err", {31'b0, er}, 32'h1);
        check("R8 unaligned data", rd, 32'h0);
        bus_xfer(1'b1, 8'h01, 32'hFFFF_FFFF, rd, er);
        bus_xfer(1'b0, 8'h00, 32'h0, rd, er);
        check("R8 mask untouched", rd, 32'h0000_0010);

        // R9: input change reaches outputs one edge later
        irq_in = '0; nmi_in = '0;
        bus_xfer(1'b1, 8'h00, 32'hFFFF_FFFF, rd, er);
        @(negedge clk);
        irq_in = 30'h20; nmi_in = 2'b01;
        #1;
        check("R9 vec before edge", {24'b0, irq_vec}, 32'h0);
        check("R9 nmi before edge", {31'b0, nmi_req}, 32'h0);
        @(negedge clk);
        check("R9 vec after edge", {24'b0, irq_vec}, 32'h36);
        check("R9 nmi after edge", {31'b0, nmi_req}, 32'h1);

        // R9: mask write effect lags the loading edge by one
        bus_xfer(1'b1, 8'h00, 32'h0, rd, er);
        check("R9 vec right after mask write", {24'b0, irq_vec}, 32'h36);
        @(negedge clk);
        check("R9 vec after mask settle", {24'b0, irq_vec}, 32'h0);
        check("R5 req off when masked", {31'b0, irq_req}, 32'h0);
        check("R6 nmi ignores mask", {31'b0, nmi_req}, 32'h1);

        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

endmodule